// File: doc/BRIEF.md
# ALU with Condition-Code Register

This block is the execute stage of a small 32-bit load-store processor. Each cycle it is handed an instruction word and the two register operands already read from the register file. It works out whether the word is a register-to-register computation or a load-upper-constant operation, picks the second operand from either the register value or a sign-extended immediate carried in the word, and produces a result together with a write-enable for the register file. Result and write-enable are combinational, so they can be consumed in the same cycle.

The block also holds a four-bit condition-code register with negative, zero, overflow and carry bits. This register is the only state in the block. Each rising clock edge it does one of three things: it clears (synchronous reset), it loads (a valid flag-setting operation is presented), or it holds (everything else). Only add, AND, OR and NOR set flags. The shifts and the load-upper operation write a result but leave the flags alone. The logical operations always leave carry and overflow at zero.

Top module: `alu_cc_top`

## Requirements
- R1: `wr_en_o` is 1 exactly when `valid_i` is 1 and the word is recognised: either bits 31:30 = 10 with bits 24:19 one of 010000, 010001, 010010, 010110, 100110, 100111, or bits 31:30 = 00 with bits 24:22 = 100. Every other word, or `valid_i` = 0, gives `wr_en_o` = 0.
- R2: When bit 13 of the word is 1, the second operand is bits 12:0 sign-extended to 32 bits (bit 12 copied upward). When bit 13 is 0, the second operand is `src_b_i`.
- R3: Opcode 010000 gives result = first + second operand modulo 2^32. It loads n = result bit 31, z = (result == 0), c = carry out of bit 31, and v = 1 when the signed sum does not fit in 32 bits.
- R4: Opcodes 010001, 010010 and 010110 give the bitwise AND, OR and NOR of the operands. They load n = result bit 31 and z = (result == 0), and they load c = 0 and v = 0.
- R5: Opcode 100110 shifts the first operand right by the low 5 bits of the second operand and fills the vacated bits with zeros.
- R6: Opcode 100111 shifts the first operand right by the low 5 bits of the second operand and fills the vacated bits with copies of the original bit 31.
- R7: The shifts, the load-upper operation, unrecognised words and cycles with `valid_i` = 0 leave the condition-code register unchanged.
- R8: The load-upper operation gives result = {bits 21:0 of the word, ten zeros}.
- R9: `flags_o` is {n, z, v, c} from bit 3 down to bit 0. It is cleared by a synchronous `rst`, and it changes only on a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the condition codes change on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the condition codes |
| valid_i | input | 1 | The instruction word this cycle is real |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | DATA_W | First register operand |
| src_b_i | input | DATA_W | Second register operand, used when bit 13 is 0 |
| result_o | output | DATA_W | Value for the register write |
| wr_en_o | output | 1 | Register write request |
| flags_o | output | 4 | Current condition codes {n, z, v, c} |

## Verification
The only internal state is the condition-code register. A wrong value there never shows on `result_o`; it appears on `flags_o` in the cycle right after the edge that should have loaded or held it. The bench therefore compares `flags_o` against its own model before every edge, so a missed hold, a spurious load or a wrong carry or overflow bit is reported one cycle after the causing instruction. Decode and operand-selection faults are combinational, so they show on `result_o` and `wr_en_o` in the same cycle as the instruction.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    localparam int INSN_W = 32;

    typedef enum logic [5:0] {
        OPC_ADD = 6'b010000,
        OPC_AND = 6'b010001,
        OPC_OR  = 6'b010010,
        OPC_NOR = 6'b010110,
        OPC_SRL = 6'b100110,
        OPC_SRA = 6'b100111
    } opc_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_ADD,
        K_AND,
        K_OR,
        K_NOR,
        K_SRL,
        K_SRA,
        K_UPPER
    } kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 13
) (
    input  logic              imm_sel,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] operand
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = {{EXT_W{imm_field[IMM_W-1]}}, imm_field};
    assign operand = imm_sel ? imm_ext : reg_val;

endmodule

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_cc_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] fmt,
    input  logic [5:0] opc,
    output kind_e      kind,
    output logic       write_en,
    output logic       set_cc
);
    always_comb begin
        kind = K_NONE;
        if (fmt == 2'b10) begin
            unique case (opc)
                OPC_ADD: kind = K_ADD;
                OPC_AND: kind = K_AND;
                OPC_OR:  kind = K_OR;
                OPC_NOR: kind = K_NOR;
                OPC_SRL: kind = K_SRL;
                OPC_SRA: kind = K_SRA;
                default: kind = K_NONE;
            endcase
        end else if (fmt == 2'b00 && opc[5:3] == 3'b100) begin
            kind = K_UPPER;
        end
    end

    always_comb begin
        write_en = valid && (kind != K_NONE);
        set_cc   = valid && (kind == K_ADD || kind == K_AND ||
                             kind == K_OR  || kind == K_NOR);
    end

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
    import alu_cc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int UPPER_W = 22
) (
    input  kind_e              kind,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    input  logic [UPPER_W-1:0] upper_field,
    output logic [DATA_W-1:0]  result,
    output cc_t                next_cc
);
    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int LOW_W   = DATA_W - UPPER_W;

    logic [DATA_W:0]       sum_ext;
    logic [SHAMT_W-1:0]    shamt;
    logic                  add_ovf;

    assign sum_ext = {1'b0, opa} + {1'b0, opb};
    assign shamt   = opb[SHAMT_W-1:0];
    assign add_ovf = (opa[DATA_W-1] == opb[DATA_W-1]) &&
                     (sum_ext[DATA_W-1] != opa[DATA_W-1]);

    always_comb begin
        unique case (kind)
            K_ADD:   result = sum_ext[DATA_W-1:0];
            K_AND:   result = opa & opb;
            K_OR:    result = opa | opb;
            K_NOR:   result = ~(opa | opb);
            K_SRL:   result = opa >> shamt;
            K_SRA:   result = $unsigned($signed(opa) >>> shamt);
            K_UPPER: result = {upper_field, {LOW_W{1'b0}}};
            default: result = '0;
        endcase
    end

    always_comb begin
        next_cc.n = result[DATA_W-1];
        next_cc.z = (result == '0);
        next_cc.v = (kind == K_ADD) && add_ovf;
        next_cc.c = (kind == K_ADD) && sum_ext[DATA_W];
    end

endmodule

// File: rtl/alu_cc_reg.sv
module alu_cc_reg
    import alu_cc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cc_t  next_cc,
    output cc_t  cc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q <= '0;
        end else if (load) begin
            cc_q <= next_cc;
        end
    end

endmodule

// File: rtl/alu_cc_top.sv
module alu_cc_top
    import alu_cc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [31:0]       insn_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o
);
    localparam int IMM_W   = 13;
    localparam int UPPER_W = 22;

    kind_e             kind;
    logic              set_cc;
    logic [DATA_W-1:0] opb;
    cc_t               next_cc;
    cc_t               cc_q;
    logic              unused_fields;

    assign unused_fields = ^{insn_i[29:25], insn_i[18:14]};

    alu_op_decode u_dec (
        .valid    (valid_i),
        .fmt      (insn_i[31:30]),
        .opc      (insn_i[24:19]),
        .kind     (kind),
        .write_en (wr_en_o),
        .set_cc   (set_cc)
    );

    alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .imm_sel   (insn_i[13]),
        .imm_field (insn_i[IMM_W-1:0]),
        .reg_val   (src_b_i),
        .operand   (opb)
    );

    alu_exec_core #(.DATA_W(DATA_W), .UPPER_W(UPPER_W)) u_core (
        .kind        (kind),
        .opa         (src_a_i),
        .opb         (opb),
        .upper_field (insn_i[UPPER_W-1:0]),
        .result      (result_o),
        .next_cc     (next_cc)
    );

    alu_cc_reg u_cc (
        .clk     (clk),
        .rst     (rst),
        .load    (set_cc),
        .next_cc (next_cc),
        .cc_q    (cc_q)
    );

    assign flags_o = cc_q;

endmodule

// File: rtl/alu_cc_chk.sv
module alu_cc_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [31:0]       insn_i,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic [3:0]        flags_o
);
    localparam int LOW_W = DATA_W - 22;

    logic arith_fmt;
    logic cc_op;
    logic logic_op;
    logic upper_op;

    assign arith_fmt = valid_i && (insn_i[31:30] == 2'b10);
    assign logic_op  = arith_fmt && (insn_i[24:19] == 6'b010001 ||
                                     insn_i[24:19] == 6'b010010 ||
                                     insn_i[24:19] == 6'b010110);
    assign cc_op     = logic_op || (arith_fmt && insn_i[24:19] == 6'b010000);
    assign upper_op  = valid_i && insn_i[31:30] == 2'b00 && insn_i[24:22] == 3'b100;

    a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !cc_op |=> $stable(flags_o));

    a_r4_logic_cv_clear: assert property (@(posedge clk) disable iff (rst)
        logic_op |=> flags_o[1:0] == 2'b00);

    a_r3_zero_flag: assert property (@(posedge clk) disable iff (rst)
        cc_op |=> flags_o[2] == ($past(result_o) == '0));

    a_r3_neg_flag: assert property (@(posedge clk) disable iff (rst)
        cc_op |=> flags_o[3] == $past(result_o[DATA_W-1]));

    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> !wr_en_o);

    a_r8_upper_low_clear: assert property (@(posedge clk) disable iff (rst)
        upper_op |-> wr_en_o && result_o[LOW_W-1:0] == '0);

endmodule

bind alu_cc_top alu_cc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (valid_i),
    .insn_i   (insn_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flags_o  (flags_o)
);

// File: tb/test_alu_cc_top.sv
module test_alu_cc_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [31:0] insn_i;
    logic [31:0] src_a_i;
    logic [31:0] src_b_i;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;

    int checks   = 0;
    int failures = 0;
    logic [3:0] mflags = 4'b0;

    always #5 clk = ~clk;

    alu_cc_top #(.DATA_W(32)) i_alu_cc_top (
        .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    function automatic logic [31:0] arith(input logic [5:0] opc, input logic isel,
                                          input logic [12:0] imm);
        return {2'b10, 5'd3, opc, 5'd1, isel, imm};
    endfunction

    function automatic logic [31:0] upper(input logic [21:0] k);
        return {2'b00, 5'd2, 3'b100, k};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // behavioural reference: result, write, flag-load and new flags
    task automatic model(input logic v, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, output logic [31:0] res, output logic we,
                         output logic setf, output logic [3:0] nf);
        logic [31:0] op2;
        logic [32:0] s33;
        longint      ssum;
        logic        cy, ov;
        op2 = ins[13] ? 32'($signed(ins[12:0])) : b;
        res = 32'h0; we = 1'b0; setf = 1'b0; cy = 1'b0; ov = 1'b0;
        if (ins[31:30] == 2'b10) begin
            we = 1'b1;
            case (ins[24:19])
                6'b010000: begin
                    s33  = {1'b0, a} + {1'b0, op2};
                    res  = s33[31:0];
                    cy   = s33[32];
                    ssum = longint'($signed(a)) + longint'($signed(op2));
                    ov   = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
                    setf = 1'b1;
                end
                6'b010001: begin res = a & op2;    setf = 1'b1; end
                6'b010010: begin res = a | op2;    setf = 1'b1; end
                6'b010110: begin res = ~(a | op2); setf = 1'b1; end
                6'b100110: res = a >> op2[4:0];
                6'b100111: res = 32'($signed(a) >>> op2[4:0]);
                default:   we = 1'b0;
            endcase
        end else if (ins[31:30] == 2'b00 && ins[24:22] == 3'b100) begin
            we  = 1'b1;
            res = {ins[21:0], 10'b0};
        end
        we   = we & v;
        setf = setf & v;
        nf   = {res[31], res == 32'h0, ov, cy};
    endtask

    function automatic string tag_for(input logic [31:0] ins);
        if (ins[31:30] == 2'b00) return "R8";
        case (ins[24:19])
            6'b010000: return "R3";
            6'b100110: return "R5";
            6'b100111: return "R6";
            6'b010001, 6'b010010, 6'b010110: return "R4";
            default:   return "R1";
        endcase
    endfunction

    task automatic step(input logic r, input logic v, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [31:0] eres;
        logic        ewe, esetf;
        logic [3:0]  enf, nxt;
        @(negedge clk);
        rst = r; valid_i = v; insn_i = ins; src_a_i = a; src_b_i = b;
        #1;
        model(v, ins, a, b, eres, ewe, esetf, enf);
        chk({tag, " write enable"}, {31'b0, wr_en_o}, {31'b0, ewe});
        if (ewe) chk({tag, " result"}, result_o, eres);
        chk({tag, " flags (R7/R9)"}, {28'b0, flags_o}, {28'b0, mflags});
        nxt = r ? 4'b0 : (esetf ? enf : mflags);
        @(posedge clk);
        mflags = nxt;
    endtask

    initial begin
        rst = 1'b1; valid_i = 1'b0; insn_i = '0; src_a_i = '0; src_b_i = '0;
        repeat (2) @(posedge clk);
        #2 chk("R9 reset clears flags", {28'b0, flags_o}, 32'h0);

        // R3: signed overflow into negative, n=1 v=1
        step(0, 1, arith(6'b010000, 0, 13'h0), 32'h7FFF_FFFF, 32'h1, "R3");
        #2 chk("R3 overflow flags", {28'b0, flags_o}, 32'hA);
        // R3: carry out with zero result, z=1 c=1
        step(0, 1, arith(6'b010000, 0, 13'h0), 32'hFFFF_FFFF, 32'h1, "R3");
        #2 chk("R3 carry flags", {28'b0, flags_o}, 32'h5);
        // R2: immediate -13 added to 5 gives -8
        step(0, 1, arith(6'b010000, 1, 13'h1FF3), 32'd5, 32'hDEAD_BEEF, "R2");
        chk("R2 sign-extended immediate sum", result_o, 32'hFFFF_FFF8);
        // R4: AND after carry-setting add clears c and v
        step(0, 1, arith(6'b010000, 0, 13'h0), 32'hFFFF_FFFF, 32'h1, "R3");
        step(0, 1, arith(6'b010001, 0, 13'h0), 32'hF0F0_0000, 32'h0FFF_0000, "R4");
        #2 chk("R4 AND clears carry", {28'b0, flags_o}, 32'h0);
        // R4: NOR of zeros is all ones, n=1
        step(0, 1, arith(6'b010110, 0, 13'h0), 32'h0, 32'h0, "R4");
        #2 chk("R4 NOR negative", {28'b0, flags_o}, 32'h8);
        step(0, 1, arith(6'b010010, 1, 13'h0F0), 32'h0, 32'h0, "R4");
        // R5: logical shift, flags untouched (R7)
        step(0, 1, arith(6'b100110, 1, 13'd31), 32'h8000_0000, 32'h0, "R5");
        chk("R5 shift by 31", result_o, 32'h0000_0001);
        // R6: arithmetic shift keeps sign
        step(0, 1, arith(6'b100111, 0, 13'h0), 32'h8000_0000, 32'd4, "R6");
        chk("R6 sign fill", result_o, 32'hF800_0000);
        // R8: load-upper
        step(0, 1, upper(22'h2ABCDE), 32'h1234_5678, 32'h0, "R8");
        chk("R8 upper constant", result_o, 32'hAAF3_7800);
        #2 chk("R7 flags after upper", {28'b0, flags_o}, {28'b0, mflags});
        // R1/R7: invalid cycle and unknown opcode
        step(0, 0, arith(6'b010000, 0, 13'h0), 32'h0, 32'h0, "R1");
        step(0, 1, arith(6'b111111, 0, 13'h0), 32'h0, 32'h0, "R1");
        // R2: register operand chosen when bit 13 clear
        step(0, 1, arith(6'b010010, 0, 13'h1FFF), 32'h0, 32'h0000_0100, "R2");
        chk("R2 register operand", result_o, 32'h0000_0100);
        // R9: mid-run reset
        step(0, 1, arith(6'b010110, 0, 13'h0), 32'h0, 32'h0, "R4");
        step(1, 0, 32'h0, 32'h0, 32'h0, "R9");
        #2 chk("R9 mid-run reset", {28'b0, flags_o}, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [5:0]  opcs [7] = '{6'b010000, 6'b010001, 6'b010010, 6'b010110,
                                      6'b100110, 6'b100111, 6'b000000};
            logic [31:0] ins;
            ins = $urandom;
            if ($urandom_range(0, 9) != 0) begin
                ins[31:30] = 2'b10;
                ins[24:19] = opcs[$urandom_range(0, 6)];
            end else if ($urandom_range(0, 1) == 1) begin
                ins[31:30] = 2'b00;
                ins[24:22] = 3'b100;
            end
            step($urandom_range(0, 99) == 0, $urandom_range(0, 7) != 0, ins,
                 $urandom, $urandom, tag_for(ins));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule